// File: doc/BRIEF.md
# Interruptible Block Copy Engine

The engine copies a run of bytes from one memory region to another. A single-cycle command carries a source address, a destination address, a byte count and a mode bit. The mode bit selects short mode, which has an 8-bit count, or long mode, which has a 16-bit count. Each byte takes one transfer cycle, and a transfer cycle is two clocks long. In the first clock the engine reads the source address. In the second clock it writes the returned byte to the destination address. After each write, both address registers step up by one and the count register steps down by one. The address and count registers are always visible at the ports, so software can inspect the progress.

While a copy runs, the engine controls which pending interrupts the processor may accept. Maskable requests are always held off until the copy ends. In short mode the non-maskable request is also held off. In long mode the non-maskable request is accepted only in the write clock that ends a transfer, and only when bytes are still left to copy. The engine then stops with an `aborted` pulse and keeps the progress it has made. Software resumes the copy by testing the remaining count and reissuing the command from the current register values. A copy that runs to the end raises `done`.

Top module: `blkcopy_engine`

## Requirements
- R1: After reset, the engine is idle. `busy`, `done`, `aborted`, `mem_rd_en` and `mem_wr_en` are all 0, and `cur_src`, `cur_dst` and `cur_cnt` are all 0.
- R2: A transfer is one clock with `mem_rd_en`=1 at the source address, then one clock with `mem_wr_en`=1 at the destination address that writes the byte just read. Read and write are never asserted together. A copy of N bytes therefore keeps the engine busy for 2N clocks.
- R3: After each write, `cur_src` and `cur_dst` each increase by 1 and `cur_cnt` decreases by 1.
- R4: `done` pulses for one clock when the count reaches zero, and at that point `cur_cnt` is 0. A command whose count is zero raises `done` in the clock after the command and makes no memory access.
- R5: While `busy` is 1, `irq_accept` is 0. While idle, `irq_accept` follows `irq_req`.
- R6: In short mode, `nmi_req` has no effect. The copy completes with `done`, no `aborted` pulse appears, and `nmi_accept` stays 0 while busy.
- R7: In long mode, if `nmi_req` is 1 during the write clock of a transfer that leaves a nonzero count, then `nmi_accept` is 1 in that clock. The engine then stops with a one-clock `aborted` pulse, and `cur_src`, `cur_dst` and `cur_cnt` reflect exactly the bytes already copied.
- R8: Reissuing the command with the current register values after an abort copies only the remaining bytes and ends with `done` and `cur_cnt`=0.
- R9: In short mode only `cmd_cnt[7:0]` is used, and the upper byte is ignored.
- R10: A `start` that arrives while busy is ignored. It does not change the addresses, the count or the bytes written.
- R11: A `nmi_req` that is 1 only during the read clock of a transfer is not accepted. `nmi_accept` is 0 in that clock, and the copy runs to completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, taken only while idle |
| cmd_long | input | 1 | Mode bit: 1 selects long mode (16-bit count), 0 selects short mode (8-bit count) |
| cmd_src | input | AW | Source start address |
| cmd_dst | input | AW | Destination start address |
| cmd_cnt | input | CW | Byte count |
| nmi_req | input | 1 | Non-maskable interrupt pending |
| irq_req | input | 1 | Maskable interrupt pending |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid one clock after the read strobe |
| busy | output | 1 | A copy is in progress |
| done | output | 1 | One-clock pulse on normal completion |
| aborted | output | 1 | One-clock pulse on a non-maskable stop |
| cur_src | output | AW | Current source address |
| cur_dst | output | AW | Current destination address |
| cur_cnt | output | CW | Remaining byte count |
| irq_accept | output | 1 | A maskable interrupt may be taken now |
| nmi_accept | output | 1 | A non-maskable interrupt may be taken now |

## Verification
The assertions assume that the memory returns read data exactly one clock after the read strobe. They also assume that `nmi_req` stays stable within a clock. The bench memory model registers its read data on the strobe edge, and the bench drives every input on the falling edge, so both conditions hold. The bench copies only between regions that do not overlap. This keeps the source bytes stable, so the expected write data can be taken from the memory model when each command is issued. The bench places each non-maskable request on a falling edge that it has counted to be inside a chosen read clock or write clock.

// File: rtl/blkcopy_pkg.sv
package blkcopy_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } xfer_state_t;
endpackage

// File: rtl/copy_fsm.sv
module copy_fsm
  import blkcopy_pkg::*;
#(
  parameter int CW  = 16,
  parameter int SCW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cmd_long,
  input  logic [CW-1:0] cmd_cnt,
  input  logic          nmi_req,
  input  logic          last_xfer,
  output xfer_state_t   state,
  output logic          long_q,
  output logic          load,
  output logic          step,
  output logic          done,
  output logic          aborted,
  output logic          busy
);
  // Short mode keeps only the low SCW bits of the count.
  function automatic logic [CW-1:0] fit_count(input logic lng, input logic [CW-1:0] c);
    logic [CW-1:0] m;
    m = lng ? c : (c & CW'({SCW{1'b1}}));
    return m;
  endfunction

  logic cmd_zero;
  logic nmi_stop;

  assign load     = (state == ST_IDLE) && start;
  assign cmd_zero = (fit_count(cmd_long, cmd_cnt) == '0);
  assign step     = (state == ST_WR);
  assign nmi_stop = step && long_q && !last_xfer && nmi_req;
  assign busy     = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      long_q  <= 1'b0;
      done    <= 1'b0;
      aborted <= 1'b0;
    end else begin
      done    <= 1'b0;
      aborted <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            long_q <= cmd_long;
            if (cmd_zero) done  <= 1'b1;
            else          state <= ST_RD;
          end
        end
        ST_RD: state <= ST_WR;
        ST_WR: begin
          if (last_xfer) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else if (nmi_stop) begin
            state   <= ST_IDLE;
            aborted <= 1'b1;
          end else begin
            state <= ST_RD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WR) |-> ($past(state) == ST_RD)); // R2
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && aborted)); // R7
  AST_ABORT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    aborted |-> long_q); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($past(long_q) == long_q)); // R10
endmodule

// File: rtl/copy_regs.sv
module copy_regs #(
  parameter int AW  = 16,
  parameter int CW  = 16,
  parameter int SCW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          cmd_long,
  input  logic [AW-1:0] cmd_src,
  input  logic [AW-1:0] cmd_dst,
  input  logic [CW-1:0] cmd_cnt,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic [CW-1:0] cnt_q,
  output logic          last_xfer
);
  function automatic logic [AW-1:0] addr_next(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  function automatic logic [CW-1:0] cnt_next(input logic [CW-1:0] c);
    return c - CW'(1);
  endfunction

  function automatic logic [CW-1:0] cnt_load(input logic lng, input logic [CW-1:0] c);
    return lng ? c : (c & CW'({SCW{1'b1}}));
  endfunction

  assign last_xfer = (cnt_q == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      src_q <= cmd_src;
      dst_q <= cmd_dst;
      cnt_q <= cnt_load(cmd_long, cmd_cnt);
    end else if (step) begin
      src_q <= addr_next(src_q);
      dst_q <= addr_next(dst_q);
      cnt_q <= cnt_next(cnt_q);
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cnt_q == $past(cnt_q) - CW'(1))); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (src_q == $past(src_q) + AW'(1)) && (dst_q == $past(dst_q) + AW'(1))); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (cnt_q != '0)); // R4
endmodule

// File: rtl/intr_gate.sv
module intr_gate (
  input  logic busy,
  input  logic long_q,
  input  logic in_wr,
  input  logic last_xfer,
  input  logic irq_req,
  input  logic nmi_req,
  output logic irq_accept,
  output logic nmi_accept
);
  logic nmi_window;

  // The only busy window for the non-maskable request is the write clock of a
  // long-mode transfer that still leaves bytes to copy.
  assign nmi_window = long_q && in_wr && !last_xfer;
  assign irq_accept = irq_req && !busy;
  assign nmi_accept = nmi_req && (!busy || nmi_window);
endmodule

// File: rtl/blkcopy_engine.sv
module blkcopy_engine
  import blkcopy_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 8,
  parameter int CW  = 16,
  parameter int SCW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cmd_long,
  input  logic [AW-1:0] cmd_src,
  input  logic [AW-1:0] cmd_dst,
  input  logic [CW-1:0] cmd_cnt,
  input  logic          nmi_req,
  input  logic          irq_req,
  output logic          mem_rd_en,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          aborted,
  output logic [AW-1:0] cur_src,
  output logic [AW-1:0] cur_dst,
  output logic [CW-1:0] cur_cnt,
  output logic          irq_accept,
  output logic          nmi_accept
);
  xfer_state_t state;
  logic        long_q;
  logic        load;
  logic        step;
  logic        last_xfer;
  logic        in_rd;

  copy_fsm #(.CW(CW), .SCW(SCW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_long(cmd_long),
    .cmd_cnt(cmd_cnt), .nmi_req(nmi_req), .last_xfer(last_xfer),
    .state(state), .long_q(long_q), .load(load), .step(step),
    .done(done), .aborted(aborted), .busy(busy)
  );

  copy_regs #(.AW(AW), .CW(CW), .SCW(SCW)) u_regs (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .cmd_long(cmd_long), .cmd_src(cmd_src), .cmd_dst(cmd_dst),
    .cmd_cnt(cmd_cnt), .src_q(cur_src), .dst_q(cur_dst),
    .cnt_q(cur_cnt), .last_xfer(last_xfer)
  );

  intr_gate u_gate (
    .busy(busy), .long_q(long_q), .in_wr(step), .last_xfer(last_xfer),
    .irq_req(irq_req), .nmi_req(nmi_req),
    .irq_accept(irq_accept), .nmi_accept(nmi_accept)
  );

  assign in_rd     = (state == ST_RD);
  assign mem_rd_en = in_rd;
  assign mem_wr_en = step;
  assign mem_addr  = step ? cur_dst : cur_src;
  assign mem_wdata = mem_rdata;

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en)); // R2
  AST_DONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cur_cnt == '0)); // R4
  AST_NO_IRQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !irq_accept); // R5
  AST_SHORT_NMI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !long_q) |-> !nmi_accept); // R6
  AST_ABORT_FROM_NMI: assert property (@(posedge clk) disable iff (!rst_n)
    aborted |-> $past(nmi_accept && busy)); // R7
  AST_NMI_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && nmi_accept) |=> (!busy && aborted)); // R7
  AST_ABORT_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    aborted |-> (cur_cnt != '0)); // R8
  AST_RD_NO_NMI: assert property (@(posedge clk) disable iff (!rst_n)
    in_rd |-> !nmi_accept); // R11
endmodule

// File: tb/blkcopy_engine_tb.sv
`timescale 1ns/1ps
module blkcopy_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        cmd_long = 1'b0;
  logic [15:0] cmd_src = '0;
  logic [15:0] cmd_dst = '0;
  logic [15:0] cmd_cnt = '0;
  logic        nmi_req = 1'b0;
  logic        irq_req = 1'b0;
  logic        mem_rd_en, mem_wr_en;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        busy, done, aborted, irq_accept, nmi_accept;
  logic [15:0] cur_src, cur_dst, cur_cnt;

  int checks = 0;
  int errors = 0;
  int reads  = 0;
  logic [7:0]  mem [1024];
  logic [23:0] expq [$];

  always #5 clk = ~clk;

  blkcopy_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_long(cmd_long),
    .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_cnt(cmd_cnt),
    .nmi_req(nmi_req), .irq_req(irq_req),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .aborted(aborted),
    .cur_src(cur_src), .cur_dst(cur_dst), .cur_cnt(cur_cnt),
    .irq_accept(irq_accept), .nmi_accept(nmi_accept)
  );

  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem[mem_addr[9:0]];
    if (mem_wr_en) mem[mem_addr[9:0]] <= mem_wdata;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected writes as they appear on the memory port.
  always @(negedge clk) begin
    if (rst_n && mem_rd_en) reads++;
    if (rst_n && mem_wr_en) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R10 unexpected write", int'(mem_addr), 0);
      end else begin
        logic [23:0] e;
        e = expq.pop_front();
        chk(mem_addr == e[23:8], "R2 write address", int'(mem_addr), int'(e[23:8]));
        chk(mem_wdata == e[7:0], "R2 write data", int'(mem_wdata), int'(e[7:0]));
      end
    end
  end

  // Driver: pushes the expected writes, then strobes the command for one clock.
  task automatic issue(input logic lng, input logic [15:0] s, input logic [15:0] d,
                       input logic [15:0] c, input int npush);
    for (int i = 0; i < npush; i++) begin
      logic [15:0] sa, da;
      sa = s + 16'(i);
      da = d + 16'(i);
      expq.push_back({da, mem[sa[9:0]]});
    end
    @(negedge clk);
    start = 1'b1; cmd_long = lng; cmd_src = s; cmd_dst = d; cmd_cnt = c;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end(output int cyc);
    cyc = 0;
    while (!(done || aborted) && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    int cyc;
    int r0;
    for (int i = 0; i < 1024; i++) mem[i] = 8'((i * 7 + 3) ^ (i >> 3));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !aborted, "R1 idle flags", {busy, done, aborted}, 0);
    chk(!mem_rd_en && !mem_wr_en, "R1 no access", {mem_rd_en, mem_wr_en}, 0);
    chk(cur_src == 0 && cur_dst == 0 && cur_cnt == 0, "R1 regs", int'(cur_cnt), 0);
    rst_n = 1'b1;

    // R2 R3 R4: plain long copy of 12 bytes.
    issue(1'b1, 16'h040, 16'h0C0, 16'd12, 12);
    wait_end(cyc);
    chk(done && !aborted, "R4 done pulse", {done, aborted}, 2);
    chk(cyc == 24, "R2 busy clocks", cyc, 24);
    chk(cur_cnt == 0, "R4 count zero", int'(cur_cnt), 0);
    chk(cur_src == 16'h04C && cur_dst == 16'h0CC, "R3 addresses", int'(cur_src), 'h04C);
    @(negedge clk);
    chk(!done, "R4 done one clock", done, 0);

    // R4: zero count, no access.
    r0 = reads;
    issue(1'b1, 16'h010, 16'h020, 16'd0, 0);
    chk(done, "R4 zero count done", done, 1);
    @(negedge clk);
    chk(reads == r0 && !busy, "R4 zero count no read", reads - r0, 0);

    // R9 R6: short mode, upper count byte ignored, NMI held throughout.
    issue(1'b0, 16'h100, 16'h180, 16'h0103, 3);
    nmi_req = 1'b1;
    #1 chk(!nmi_accept, "R6 nmi held in rd", nmi_accept, 0);
    @(negedge clk);
    #1 chk(!nmi_accept, "R6 nmi held in wr", nmi_accept, 0);
    wait_end(cyc);
    chk(done && !aborted, "R6 short completes", {done, aborted}, 2);
    chk(cur_src == 16'h103 && cur_cnt == 0, "R9 three bytes", int'(cur_src), 'h103);
    @(negedge clk);
    chk(nmi_accept, "R6 nmi accepted when idle", nmi_accept, 1);
    nmi_req = 1'b0;

    // R10 R5: start while busy, maskable request pending.
    issue(1'b0, 16'h200, 16'h280, 16'd6, 6);
    start = 1'b1; cmd_src = 16'h3F0; cmd_dst = 16'h3F8; cmd_cnt = 16'd2; irq_req = 1'b1;
    #1 chk(!irq_accept, "R5 irq held while busy", irq_accept, 0);
    @(negedge clk);
    start = 1'b0;
    wait_end(cyc);
    chk(cur_src == 16'h206 && cur_dst == 16'h286, "R10 start ignored", int'(cur_src), 'h206);
    @(negedge clk);
    chk(irq_accept, "R5 irq follows when idle", irq_accept, 1);
    irq_req = 1'b0;

    // R7 R8: long copy of 10, NMI in write clock of transfer 3, then resume.
    issue(1'b1, 16'h300, 16'h380, 16'd10, 3);
    repeat (5) @(negedge clk);
    nmi_req = 1'b1;
    #1 chk(nmi_accept, "R7 nmi accepted at boundary", nmi_accept, 1);
    wait_end(cyc);
    nmi_req = 1'b0;
    chk(aborted && !done, "R7 aborted pulse", {done, aborted}, 1);
    chk(cur_cnt == 7, "R7 count kept", int'(cur_cnt), 7);
    chk(cur_src == 16'h303 && cur_dst == 16'h383, "R7 addresses kept", int'(cur_src), 'h303);
    issue(1'b1, cur_src, cur_dst, cur_cnt, 7);
    wait_end(cyc);
    chk(done && cur_cnt == 0, "R8 resume completes", int'(cur_cnt), 0);
    chk(cur_src == 16'h30A, "R8 resume address", int'(cur_src), 'h30A);

    // R11: NMI only during the read clock is not taken.
    issue(1'b1, 16'h140, 16'h1C0, 16'd4, 4);
    nmi_req = 1'b1;
    #1 chk(!nmi_accept, "R11 nmi in read clock", nmi_accept, 0);
    @(negedge clk);
    nmi_req = 1'b0;
    wait_end(cyc);
    chk(done && !aborted && cur_cnt == 0, "R11 copy completes", {done, aborted}, 2);

    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R2 all writes seen", expq.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule